// File: doc/BRIEF.md
# Phase Voltage Routing and Sample Capture

This block sits between three signed 24-bit phase-voltage sample streams and the three per-phase computational datapaths of a metering core. On every sample strobe (nominally 8 kSPS) it latches the raw phase samples into three waveform registers. In the same cycle it latches, for each datapath, the phase voltage chosen by a 2-bit routing field. Each datapath decodes its field with its own rotated encoding, so the same code names a different phase in each path. The reserved code selects the path's own phase.

Each capture raises a data-ready flag, which software clears by writing a one to it. The flag can drive an active-low interrupt through a mask bit. A simple register bus gives access to the routing fields, a filter-bypass control, the status and mask registers, and the waveform registers. Waveform registers read back sign-extended to 32 bits. Routing changes only apply at the next strobe, so a captured set never mixes two configurations.

Top module: `phase_volt_router`

Register map (byte-free word addresses on `bus_addr`): 0 routing, 1 filter control, 2 status, 3 mask, 4/5/6 waveform A/B/C, 7 reads zero.

## Requirements
- R1: Routing bits [9:8] pick the sample for datapath A: 00 phase A, 01 phase B, 10 phase C.
- R2: Routing bits [11:10] pick the sample for datapath B: 00 phase B, 01 phase C, 10 phase A.
- R3: Routing bits [13:12] pick the sample for datapath C: 00 phase C, 01 phase A, 10 phase B.
- R4: Code 11 in any routing field behaves exactly like 00, giving the path's own phase.
- R5: After reset all routing fields, the filter bit, the status flag, the mask, all datapath outputs and all waveform registers are 0, and `irq_n` is 1.
- R6: Waveform registers (addresses 4, 5, 6) and datapath outputs update only in the cycle after `smp_stb` is high, and hold otherwise.
- R7: Status bit 17 (address 2) is set by each strobe and cleared by writing 1 to bit 17. Writing 0 leaves it unchanged, and a strobe in the same cycle as the clear wins.
- R8: `irq_n` is 0 exactly when status bit 17 and mask bit 17 (address 3) are both 1.
- R9: Waveform reads return the 24-bit sample with bit 23 copied into bits 31:24.
- R10: A routing write between strobes does not change the datapath outputs until the next strobe.
- R11: Bit 0 of address 1 is readable and drives `hpf_bypass` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_in | input | 24 | Phase A voltage sample, signed |
| vb_in | input | 24 | Phase B voltage sample, signed |
| vc_in | input | 24 | Phase C voltage sample, signed |
| smp_stb | input | 1 | One-cycle sample strobe |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| path_a | output | 24 | Sample for datapath A |
| path_b | output | 24 | Sample for datapath B |
| path_c | output | 24 | Sample for datapath C |
| hpf_bypass | output | 1 | High-pass bypass control |
| irq_n | output | 1 | Active-low data-ready interrupt |

## Verification
The routing properties compare a datapath output with the strobe-time value of a source input. They therefore assume the phase inputs are meaningful only while `smp_stb` is high, and that the strobe is a single-cycle pulse after reset. The bench drives the inputs and the strobe together on the falling edge and raises the strobe only for one cycle at a time. It sweeps all 64 combinations of the three routing fields, with signed samples of both polarities.

// File: rtl/phase_volt_router.sv
module phase_volt_router #(
  parameter int DW = 24,
  parameter int RW = 32,
  parameter int AW = 3,
  parameter int FLAG_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] va_in,
  input  logic [DW-1:0] vb_in,
  input  logic [DW-1:0] vc_in,
  input  logic          smp_stb,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  output logic [DW-1:0] path_a,
  output logic [DW-1:0] path_b,
  output logic [DW-1:0] path_c,
  output logic          hpf_bypass,
  output logic          irq_n
);
  localparam int NPH = 3;
  localparam int EXT = RW - DW;
  localparam logic [AW-1:0] A_ROUTE = AW'(0);
  localparam logic [AW-1:0] A_FILT  = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);
  localparam logic [AW-1:0] A_MASK  = AW'(3);
  localparam logic [AW-1:0] A_WAVA  = AW'(4);
  localparam logic [AW-1:0] A_WAVB  = AW'(5);
  localparam logic [AW-1:0] A_WAVC  = AW'(6);

  logic [5:0]    route;
  logic          filt_off, flag, mask;
  logic [DW-1:0] vin  [NPH];
  logic [DW-1:0] wave [NPH];
  logic [DW-1:0] dp   [NPH];

  assign vin[0] = va_in;
  assign vin[1] = vb_in;
  assign vin[2] = vc_in;

  wire clr_hit = bus_wr && bus_addr == A_STAT && bus_wdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      route <= '0; filt_off <= 1'b0; mask <= 1'b0; flag <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_ROUTE) route <= bus_wdata[13:8];
      if (bus_wr && bus_addr == A_FILT) filt_off <= bus_wdata[0];
      if (bus_wr && bus_addr == A_MASK) mask <= bus_wdata[FLAG_BIT];
      if (smp_stb) flag <= 1'b1;
      else if (clr_hit) flag <= 1'b0;
    end

  for (genvar g = 0; g < NPH; g++) begin : g_path
    logic [1:0] code;
    logic [2:0] sum;
    logic [1:0] src;
    assign code = route[2*g +: 2];
    assign sum  = 3'(g) + {1'b0, code};
    assign src  = (code == 2'b11) ? 2'(g) : (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wave[g] <= '0; dp[g] <= '0;
      end else if (smp_stb) begin
        wave[g] <= vin[g];
        dp[g]   <= vin[src];
      end
  end

  function automatic logic [RW-1:0] sext(input logic [DW-1:0] v);
    return {{EXT{v[DW-1]}}, v};
  endfunction

  always_comb
    case (bus_addr)
      A_ROUTE: bus_rdata = RW'({route, 8'h00});
      A_FILT:  bus_rdata = RW'(filt_off);
      A_STAT:  bus_rdata = RW'(flag) << FLAG_BIT;
      A_MASK:  bus_rdata = RW'(mask) << FLAG_BIT;
      A_WAVA:  bus_rdata = sext(wave[0]);
      A_WAVB:  bus_rdata = sext(wave[1]);
      A_WAVC:  bus_rdata = sext(wave[2]);
      default: bus_rdata = '0;
    endcase

  assign path_a     = dp[0];
  assign path_b     = dp[1];
  assign path_c     = dp[2];
  assign hpf_bypass = filt_off;
  assign irq_n      = ~(flag & mask);
endmodule

module phase_volt_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] va_in,
  input logic [23:0] vb_in,
  input logic [23:0] vc_in,
  input logic        smp_stb,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic [5:0]  route,
  input logic        flag,
  input logic [23:0] path_a,
  input logic [23:0] path_b,
  input logic [23:0] path_c,
  input logic        irq_n
);
  p_route_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb) && $past(route[1:0]) == 2'b01 |-> path_a == $past(vb_in));
  p_route_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb) && $past(route[3:2]) == 2'b10 |-> path_b == $past(va_in));
  p_route_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb) && $past(route[5:4]) == 2'b01 |-> path_c == $past(va_in));
  p_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb) && $past(route[1:0]) == 2'b11 |-> path_a == $past(va_in));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> $stable(path_a) && $stable(path_b) && $stable(path_c));
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> flag);
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> irq_n);
  p_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr >= 3'd4 && bus_addr <= 3'd6 |-> bus_rdata[31:24] == {8{bus_rdata[23]}});
endmodule

bind phase_volt_router phase_volt_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .va_in(va_in), .vb_in(vb_in), .vc_in(vc_in),
  .smp_stb(smp_stb), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .route(route), .flag(flag), .path_a(path_a), .path_b(path_b),
  .path_c(path_c), .irq_n(irq_n)
);

// File: tb/phase_volt_router_bench.sv
module phase_volt_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] va_in = '0, vb_in = '0, vc_in = '0;
  logic        smp_stb = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] path_a, path_b, path_c;
  logic        hpf_bypass, irq_n;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  phase_volt_router u_phase_volt_router (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic strobe(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
    @(negedge clk); va_in = a; vb_in = b; vc_in = c; smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0; va_in = '0; vb_in = '0; vc_in = '0;
  endtask

  function automatic logic [23:0] pick(input int own, input logic [1:0] code,
                                       input logic [23:0] a, input logic [23:0] b, input logic [23:0] c);
    int idx;
    idx = (code == 2'b11) ? own : (own + int'(code)) % 3;
    return idx == 0 ? a : idx == 1 ? b : c;
  endfunction

  function automatic logic [31:0] sx(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  initial begin
    logic [31:0] r;
    logic [23:0] a, b, c;
    #35;
    // R5: reset state
    rd(3'd0, r); chk("R5 route", r, 0);
    rd(3'd2, r); chk("R5 status", r, 0);
    rd(3'd4, r); chk("R5 wave", r, 0);
    chk("R5 irq_n", 32'(irq_n), 1);
    chk("R5 paths", {8'h0, path_a | path_b | path_c}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 R2 R3 R4 R9: all routing combinations
    for (int k = 0; k < 64; k++) begin
      wr(3'd0, 32'(k) << 8);
      rd(3'd0, r); chk("R1 route readback", r, 32'(k) << 8);
      a = 24'h800001 ^ 24'(k * 7);
      b = 24'h123456 + 24'(k);
      c = 24'hFEDCBA - 24'(k * 3);
      strobe(a, b, c);
      chk("R1 path_a", 32'(path_a), 32'(pick(0, 2'(k), a, b, c)));
      chk("R2 path_b", 32'(path_b), 32'(pick(1, 2'(k >> 2), a, b, c)));
      chk("R3 path_c", 32'(path_c), 32'(pick(2, 2'(k >> 4), a, b, c)));
      rd(3'd4, r); chk("R9 wave a", r, sx(a));
      rd(3'd5, r); chk("R9 wave b", r, sx(b));
      rd(3'd6, r); chk("R9 wave c", r, sx(c));
    end
    // R4 explicit fallback on all three paths
    wr(3'd0, 32'h3F00);
    strobe(24'h000111, 24'h000222, 24'h000333);
    chk("R4 path_a", 32'(path_a), 32'h111);
    chk("R4 path_b", 32'(path_b), 32'h222);
    chk("R4 path_c", 32'(path_c), 32'h333);
    // R10 / R6: routing write without strobe keeps outputs
    wr(3'd0, 32'h1500);
    @(negedge clk); @(negedge clk);
    chk("R10 path_a held", 32'(path_a), 32'h111);
    chk("R6 path_c held", 32'(path_c), 32'h333);
    rd(3'd6, r); chk("R6 wave c held", r, 32'h333);
    strobe(24'h000AAA, 24'h000BBB, 24'h000CCC);
    chk("R10 path_a new", 32'(path_a), 32'hBBB);
    chk("R10 path_b new", 32'(path_b), 32'hCCC);
    // R7 status W1C
    rd(3'd2, r); chk("R7 flag set", r, 32'h20000);
    wr(3'd2, 32'h0);
    rd(3'd2, r); chk("R7 write zero", r, 32'h20000);
    chk("R8 masked off", 32'(irq_n), 1);
    wr(3'd3, 32'h20000);
    rd(3'd3, r); chk("R8 mask readback", r, 32'h20000);
    chk("R8 irq asserted", 32'(irq_n), 0);
    wr(3'd2, 32'h20000);
    rd(3'd2, r); chk("R7 cleared", r, 0);
    chk("R8 irq released", 32'(irq_n), 1);
    // R7 strobe wins over clear
    strobe(24'h1, 24'h2, 24'h3);
    @(negedge clk); bus_addr = 3'd2; bus_wdata = 32'h20000; bus_wr = 1'b1;
    va_in = 24'h4; vb_in = 24'h5; vc_in = 24'h6; smp_stb = 1'b1;
    @(negedge clk); bus_wr = 1'b0; smp_stb = 1'b0;
    rd(3'd2, r); chk("R7 set wins", r, 32'h20000);
    chk("R8 irq with set", 32'(irq_n), 0);
    // R11 filter bypass
    wr(3'd1, 32'h1);
    chk("R11 bypass on", 32'(hpf_bypass), 1);
    rd(3'd1, r); chk("R11 readback", r, 1);
    wr(3'd1, 32'h0);
    chk("R11 bypass off", 32'(hpf_bypass), 0);
    rd(3'd7, r); chk("R9 unused addr", r, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (50000) @(posedge clk); fails++; $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule